// File: doc/BRIEF.md
# Three-Wire Bidirectional SPI Master

This block is the master end of a serial configuration link whose data travels on one shared wire in both directions, for instance a converter's setup port reached through a pair of differential line buffers. It generates the serial clock and a chip select whose active level the host chooses. It also drives two direction controls, one for the buffer next to the master and one for the buffer at the far end, so that the shared wire can be turned around between driving and listening. The shared wire is presented as three signals: a data output, an output enable and a data input.

The host issues one word per command. It raises `start` together with the direction of the transfer (`is_read`), a flag closing the frame (`last`), a flag announcing that a read comes next (`read_next`), the clock mode and the chip-select level. The block then reports `busy` until it pulses `done`. Words issued without `last` keep chip select asserted, so a frame can chain writes and reads. Data is inverted on the wire in both directions. The serial clock rests at the inverse of mode bit 1. A write followed by a read in phase 1 hands the wire over during the idle half of its final bit.

Top module: `tw_spi_master`

## Requirements
- R1: In the cycle after a synchronous reset, `busy` and `done` are 0, both direction outputs are 1 (drive), `cs` equals the inverse of `cs_active`, and `sclk` is at its idle level.
- R2: When no transfer runs, `sclk` equals NOT `mode[1]`. During a transfer, the active level of `sclk` equals `mode[1]`.
- R3: A write sends the bitwise inverse of `wdata`, most significant bit first. The line value is valid at each idle-to-active `sclk` edge. The write lasts 2×WORD_W half periods of HALF_CYC clock cycles. In phase 0 (`mode[0]`=0) each bit begins with an idle half. In phase 1 each bit begins with an active half.
- R4: A read sets both direction outputs to 0 (receive) from the cycle after `start`. It waits one idle half before the first active half. It samples `sdio_i` at the end of the idle half before each active half in phase 0, and at the end of each active half in phase 1. It returns the bitwise inverse of the bits assembled MSB first. It lasts 2×WORD_W+1 half periods.
- R5: `cs` takes the level `cs_active` from the cycle after an accepted `start`. It stays at that level through chained words and returns to the inverse level only when a word flagged `last` completes.
- R6: When a write flagged `last` completes, both direction outputs are 0 and `cs` is released.
- R7: In a phase-1 write with `read_next` set, both direction outputs fall to 0 exactly (2×WORD_W−1)×HALF_CYC cycles after `start` is accepted. In a phase-0 write that is not `last`, they stay 1 after completion.
- R8: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse and `rdata` is valid when it is high. Chip select does not change while `busy` stays high.
- R9: `sdio_oe` is 1 exactly when the direction outputs select drive.
- R10: During a write, `sdio_o` holds steady throughout each half period.
- R11: A `start` raised while `busy` is high is ignored. It produces no extra `done` and does not alter the word in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch a one-word transfer (ignored while busy) |
| is_read | input | 1 | 1 = read word, 0 = write word |
| last | input | 1 | Word closes the frame and releases chip select |
| read_next | input | 1 | A read follows this write (early turnaround in phase 1) |
| mode | input | 2 | Bit 0 phase, bit 1 inverse of the clock idle level |
| cs_active | input | 1 | Level of chip select while asserted |
| wdata | input | WORD_W | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | WORD_W | Word read, valid with done |
| sclk | output | 1 | Serial clock |
| cs | output | 1 | Chip select |
| dir_local | output | 1 | Near buffer direction, 1 = drive |
| dir_remote | output | 1 | Far buffer direction, 1 = drive |
| sdio_o | output | 1 | Shared line, value driven |
| sdio_oe | output | 1 | Shared line, output enable |
| sdio_i | input | 1 | Shared line, value received |

## Verification
On every cycle the assertions check several invariants. The clock rests at NOT `mode[1]` whenever the block is free. `done` never lasts two cycles. Chip select is frozen while a word is in flight. Write data never moves within a half period. A read releases the wire as soon as it starts. Other behaviour shows only in the bench's scenarios with a modelled far end. These are the inverted bit order on the wire in each phase, the exact length of each word, and the read value assembled from each sampling point. The scenarios also show the early turnaround cycle, chip select persisting across chained words, and a `start` pulse during a transfer being ignored.

// File: rtl/tw_spi_pkg.sv
// Package: shared types and helpers for the three-wire SPI master.
// Assumes: half periods of a word are numbered from 0.
package tw_spi_pkg;

    // One host command, captured when a transfer is accepted.
    typedef struct packed {
        logic rd;       // 1 = read word
        logic last;     // word closes the frame
        logic rd_next;  // a read follows this write
        logic ph;       // clock phase (mode bit 0)
    } tw_cmd_t;

    // Whether half period with the given index parity has SCLK active.
    // Reads and phase-0 writes lead with an idle half; phase-1 writes lead active.
    function automatic logic half_is_active(tw_cmd_t c, logic idx_odd);
        return c.rd ? idx_odd : (idx_odd ^ c.ph);
    endfunction

endpackage

// File: rtl/tw_spi_halftimer.sv
// Module: half-period timer. Counts HALF_CYC system cycles and pulses
// tick on the last cycle of each half period while run is high.
// Assumes: HALF_CYC >= 1; restart has priority over counting.
module tw_spi_halftimer #(
    parameter int HALF_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] CMAX = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CMAX);

    // Purpose: advance the cycle count within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tw_spi_shreg.sv
// Module: shift register shared by both directions. Loads a parallel word
// for writes, shifts left with a serial bit on the right for both directions.
// Assumes: W >= 2; load has priority over shift.
module tw_spi_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] par_out
);
    logic [W-1:0] sh_q;

    assign par_out = sh_q;

    // Purpose: hold, load or shift the word, MSB leaving first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], ser_in};
        end
    end
endmodule

// File: rtl/tw_spi_seq.sv
// Module: transfer sequencer. Walks the half periods of one word, decides the
// clock level of each half, the line direction, the frame (chip select) state,
// and when to shift out or sample in.
// Assumes: tick comes from a timer restarted on accept; commands arrive only
// through start while not busy.
module tw_spi_seq
    import tw_spi_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  tw_cmd_t cmd_in,
    input  logic    tick,
    output logic    accept,
    output logic    busy,
    output logic    done,
    output logic    act,
    output logic    drive,
    output logic    frame,
    output logic    shift_en,
    output logic    sample_en,
    output logic    finish_rd
);
    localparam int HALVES_WR = 2 * WORD_W;
    localparam int HALVES_RD = 2 * WORD_W + 1;
    localparam int IW        = $clog2(HALVES_RD + 1);
    localparam logic [IW-1:0] LAST_WR = IW'(HALVES_WR - 1);
    localparam logic [IW-1:0] LAST_RD = IW'(HALVES_RD - 1);

    tw_cmd_t       cmd_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_nx;
    logic          busy_q, done_q, act_q, drive_q, frame_q;
    logic          adv, last_half, turn_early;

    assign accept     = start && !busy_q;
    assign adv        = busy_q && tick;
    assign idx_nx     = idx_q + 1'b1;
    assign last_half  = (idx_q == (cmd_q.rd ? LAST_RD : LAST_WR));
    assign turn_early = !cmd_q.rd && cmd_q.ph && cmd_q.rd_next && (idx_nx == LAST_WR);

    // Purpose: write bits move on after each odd half, except the final one.
    assign shift_en  = adv && !cmd_q.rd && idx_q[0] && !last_half;
    // Purpose: read samples before an active half (phase 0) or at its end (phase 1).
    assign sample_en = adv && cmd_q.rd &&
                       ((!cmd_q.ph && !idx_q[0] && !last_half) || (cmd_q.ph && idx_q[0]));
    assign finish_rd = adv && last_half && cmd_q.rd;

    assign busy  = busy_q;
    assign done  = done_q;
    assign act   = act_q;
    assign drive = drive_q;
    assign frame = frame_q;

    // Purpose: step through the half periods of the accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            idx_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            act_q   <= 1'b0;
            drive_q <= 1'b1;
            frame_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                cmd_q   <= cmd_in;
                idx_q   <= '0;
                busy_q  <= 1'b1;
                frame_q <= 1'b1;
                drive_q <= !cmd_in.rd;
                act_q   <= half_is_active(cmd_in, 1'b0);
            end else if (adv) begin
                if (last_half) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    act_q  <= 1'b0;
                    if (cmd_q.last) begin
                        frame_q <= 1'b0;
                        drive_q <= 1'b0;
                    end
                end else begin
                    idx_q <= idx_nx;
                    act_q <= half_is_active(cmd_q, idx_nx[0]);
                    if (turn_early) begin
                        drive_q <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tw_spi_master.sv
// Module: top of the three-wire bidirectional SPI master. Joins the timer,
// sequencer and shift register, maps the clock mode and chip-select level
// onto the pins and presents the inverted read word.
// Assumes: the host holds mode and cs_active steady while busy; the shared
// line is resolved outside from sdio_o / sdio_oe / sdio_i.
module tw_spi_master
    import tw_spi_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int CLK_HZ  = 100_000_000,
    parameter int SCLK_HZ = 500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic              last,
    input  logic              read_next,
    input  logic [1:0]        mode,
    input  logic              cs_active,
    input  logic [WORD_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              sclk,
    output logic              cs,
    output logic              dir_local,
    output logic              dir_remote,
    output logic              sdio_o,
    output logic              sdio_oe,
    input  logic              sdio_i
);
    localparam int HALF_CYC_RAW = CLK_HZ / (2 * SCLK_HZ);
    localparam int HALF_CYC     = (HALF_CYC_RAW < 1) ? 1 : HALF_CYC_RAW;

    tw_cmd_t           cmd_in;
    logic              accept, tick, act, drive, frame;
    logic              shift_en, sample_en, finish_rd;
    logic [1:0]        mode_q;
    logic              csp_q;
    logic [WORD_W-1:0] sh_word;
    logic [WORD_W-1:0] rdata_q;

    assign cmd_in = '{rd: is_read, last: last, rd_next: read_next, ph: mode[0]};

    tw_spi_halftimer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy),
        .tick    (tick)
    );

    tw_spi_seq #(.WORD_W(WORD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_in    (cmd_in),
        .tick      (tick),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .act       (act),
        .drive     (drive),
        .frame     (frame),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .finish_rd (finish_rd)
    );

    tw_spi_shreg #(.W(WORD_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && !is_read),
        .load_val (~wdata),
        .shift    (shift_en || sample_en),
        .ser_in   (sdio_i),
        .par_out  (sh_word)
    );

    // Purpose: track the clock mode while free so the idle level follows it.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            mode_q <= mode;
        end
    end

    // Purpose: latch the chip-select level only while no frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n || (!busy && !frame)) begin
            csp_q <= cs_active;
        end
    end

    // Purpose: present the inverted read word when a read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (finish_rd) begin
            rdata_q <= ~sh_word;
        end
    end

    assign rdata      = rdata_q;
    assign sclk       = act ? mode_q[1] : ~mode_q[1];
    assign cs         = frame ? csp_q : ~csp_q;
    assign dir_local  = drive;
    assign dir_remote = drive;
    assign sdio_oe    = drive;
    assign sdio_o     = sh_word[WORD_W-1];
endmodule

// File: rtl/tw_spi_master_chk.sv
// Module: property checker for the three-wire SPI master, bound to the top.
// Assumes: observes ports only.
module tw_spi_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       is_read,
    input logic [1:0] mode,
    input logic       busy,
    input logic       done,
    input logic       sclk,
    input logic       cs,
    input logic       dir_local,
    input logic       dir_remote,
    input logic       sdio_o,
    input logic       sdio_oe
);
    AST_SCLK_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (sclk == !$past(mode[1]))); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_CS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs)); // R8

    AST_READ_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(start && is_read)) |-> (!dir_local && !dir_remote)); // R4

    AST_WRITE_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sdio_oe && $past(sdio_oe) && $stable(sclk)) |-> $stable(sdio_o)); // R10
endmodule

bind tw_spi_master tw_spi_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_read    (is_read),
    .mode       (mode),
    .busy       (busy),
    .done       (done),
    .sclk       (sclk),
    .cs         (cs),
    .dir_local  (dir_local),
    .dir_remote (dir_remote),
    .sdio_o     (sdio_o),
    .sdio_oe    (sdio_oe)
);

// File: tb/tw_spi_master_bench.sv
// Bench: scoreboard for the three-wire SPI master. The driver queues the
// expected line word or read result; the monitor models the far end and
// compares on each done.
module tw_spi_master_bench;
    localparam int W = 8;
    localparam int H = 5;   // 250 MHz / (2 * 25 MHz)

    typedef struct {
        bit         rd;
        logic [W-1:0] val;
        int         len;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0, is_read = 1'b0, last_i = 1'b0, read_next = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         cs_active = 1'b0;
    logic [W-1:0] wdata = '0;
    logic         busy, done, sclk, cs, dir_local, dir_remote, sdio_o, sdio_oe;
    logic [W-1:0] rdata;
    logic         sdio_i = 1'b0;

    int errors = 0, checks = 0, cyc = 0, t0 = 0, dirfall = -1;
    int pushed = 0, seen = 0;
    bit finished = 0;
    exp_t q[$];
    logic [1:0]   cur_mode = 2'b00;
    logic [W-1:0] line_word = '0;
    logic [W-1:0] cap = '0;
    int  bidx = 0;
    bit  prev_act = 0, prev_busy = 0, prev_dir = 1;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tw_spi_master #(.WORD_W(W), .CLK_HZ(250_000_000), .SCLK_HZ(25_000_000)) u_tw_spi_master (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read), .last(last_i),
        .read_next(read_next), .mode(mode), .cs_active(cs_active), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata), .sclk(sclk), .cs(cs),
        .dir_local(dir_local), .dir_remote(dir_remote), .sdio_o(sdio_o),
        .sdio_oe(sdio_oe), .sdio_i(sdio_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // Monitor: far-end model and scoreboard comparison.
    always @(negedge clk) begin
        bit a;
        a = (sclk == cur_mode[1]);
        if (busy && !prev_busy) begin
            t0 = cyc; cap = '0; dirfall = -1;
            bidx = cur_mode[0] ? W - 1 : W - 2;
            if (!cur_mode[0]) sdio_i = line_word[W-1];
        end
        if (busy && prev_dir && !dir_local) dirfall = cyc - t0;
        if (busy && a && (!prev_act || !prev_busy)) begin
            if (sdio_oe) cap = {cap[W-2:0], sdio_o};
            if (cur_mode[0] && bidx >= 0) begin sdio_i = line_word[bidx]; bidx--; end
        end
        if (busy && prev_busy && !a && prev_act && !cur_mode[0] && bidx >= 0) begin
            sdio_i = line_word[bidx]; bidx--;
        end
        if (done) begin
            seen++;
            if (q.size() == 0) begin
                chk(0, "R11 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.rd) chk(rdata == e.val, "R4 read value", rdata, e.val);
                else      chk(cap == e.val, "R3 line word", cap, e.val);
                chk((cyc - t0) == e.len, e.rd ? "R4 length" : "R3 length", cyc - t0, e.len);
            end
        end
        prev_act = busy && a; prev_busy = busy; prev_dir = dir_local;
    end

    task automatic xfer(input bit rd, input bit lst, input bit rdn, input logic [1:0] md,
                        input bit csa, input logic [W-1:0] wd, input logic [W-1:0] lw);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        cur_mode = md; line_word = lw;
        is_read = rd; last_i = lst; read_next = rdn; mode = md; cs_active = csa; wdata = wd;
        e.rd = rd; e.val = rd ? ~lw : ~wd; e.len = (rd ? 2 * W + 1 : 2 * W) * H;
        q.push_back(e); pushed++;
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk(dir_local && dir_remote, "R1 drive", {dir_local, dir_remote}, 3);
        chk(cs == 1'b1, "R1 cs inactive", cs, 1);
        chk(sclk == 1'b1, "R1 R2 sclk idle", sclk, 1);
        chk(sdio_oe == 1'b1, "R9 oe drive", sdio_oe, 1);
        // R2: idle level follows mode bit 1
        mode = 2'b10; cur_mode = 2'b10;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R2 idle low", sclk, 0);

        // R3 R6: phase-0 write, last
        xfer(0, 1, 0, 2'b00, 0, 8'hA5, 8'h00);
        repeat (8) @(negedge clk);
        chk(cs == 1'b0 && busy, "R5 R8 cs asserted busy", {cs, busy}, 1);
        wait_done();
        chk(!dir_local && !dir_remote && !sdio_oe, "R6 R9 receive after last write", {dir_local, sdio_oe}, 0);
        chk(cs == 1'b1, "R6 cs released", cs, 1);

        // R4: phase-0 read
        xfer(1, 1, 0, 2'b00, 0, 8'h00, 8'h3C);
        repeat (3) @(negedge clk);
        chk(!dir_local && !dir_remote, "R4 receive during read", {dir_local, dir_remote}, 0);
        wait_done();

        // R7 R5: phase-1 chained write then read, cs active high
        xfer(0, 0, 1, 2'b01, 1, 8'h5A, 8'h00);
        wait_done();
        chk(dirfall == (2 * W - 1) * H, "R7 early turnaround cycle", dirfall, (2 * W - 1) * H);
        chk(cs == 1'b1, "R5 cs held between words", cs, 1);
        xfer(1, 1, 0, 2'b01, 1, 8'h00, 8'h96);
        wait_done();
        chk(cs == 1'b0, "R5 cs released after last", cs, 0);

        // R2 R3: mode 11 write
        xfer(0, 1, 0, 2'b11, 0, 8'hF0, 8'h00);
        wait_done();
        // R4: mode 10 read
        xfer(1, 1, 0, 2'b10, 0, 8'h00, 8'h01);
        wait_done();

        // R7: phase-0 write not last keeps driving, then read closes frame
        xfer(0, 0, 1, 2'b00, 0, 8'hC3, 8'h00);
        wait_done();
        chk(dir_local && sdio_oe, "R7 phase0 keeps drive", {dir_local, sdio_oe}, 3);
        chk(cs == 1'b0, "R5 cs held phase0 chain", cs, 0);
        xfer(1, 1, 0, 2'b00, 0, 8'h00, 8'hE7);
        wait_done();

        // R11: start pulse during busy ignored
        xfer(0, 1, 0, 2'b00, 0, 8'h81, 8'h00);
        repeat (20) @(negedge clk);
        wdata = 8'hFF; start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        repeat (120) @(negedge clk);
        chk(seen == pushed && q.size() == 0, "R11 no extra done", seen, pushed);
        chk(busy == 1'b0, "R11 idle after ignored start", busy, 0);

        finish_run();
    end
endmodule